// File: doc/BRIEF.md
# Segmented Vector Element Broadcast Unit

This block decodes one vector instruction and executes it on a wide source operand. The operand is split into 128-bit segments. In each segment the unit picks one element and copies it into every element slot of the same segment of the result. The element size and the element index share one packed field in the instruction word. The lowest set bit of the size part of that field sets the element size. The bits above that set bit form the index.

The unit takes an instruction word, a source vector and a feature-enable level, all qualified by an input valid. It returns the result vector, the destination register number, an opcode-match flag and an undefined-instruction flag. The latency is fixed and the unit accepts a new word every cycle. When the word does not carry this block's fixed opcode bits, the match flag drops and the undefined flag stays low, so another decoder can claim the word. The vector width `VL_BITS` is set when the block is built. It must be a multiple of 128 between 128 and 2048, and elaboration stops for any other value.

Top module: `seg_bcast_unit`

## Requirements
- R1: A word matches only when bits [31:24] = 0x05, bits [23:21] = 001 and bits [15:10] = 001001. On a word that does not match, out_match, out_undef, out_dst and out_result are all zero.
- R2: A matching word whose size field (bits [19:16]) is 0000 raises out_undef.
- R3: A matching word sampled while in_feat_en is low raises out_undef.
- R4: While out_undef is high, out_result is all zeros.
- R5: If bit 16 is 1, elements are 8 bits wide and the index is {bit 20, bits 19:17}, giving 0 to 15.
- R6: If bits [17:16] = 10, elements are 16 bits wide and the index is {bit 20, bits 19:18}, giving 0 to 7.
- R7: If bits [18:16] = 100, elements are 32 bits wide and the index is {bit 20, bit 19}, giving 0 to 3.
- R8: If bits [19:16] = 1000, elements are 64 bits wide and the index is bit 20, giving 0 or 1.
- R9: For every segment s, result bits [128s+127:128s] hold copies of source element `index` of segment s. Element e of that segment occupies source bits starting at 128s + e·esize. Each segment draws only on its own source segment.
- R10: out_valid rises two clock edges after in_valid is sampled high. Words sent on consecutive cycles give results on consecutive cycles, in order, and the latency does not depend on data values.
- R11: On a matching word, out_dst equals instruction bits [4:0], including when out_undef is set.
- R12: While reset is held and right after it, out_valid is low and all other outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the word and operand in this cycle |
| in_insn | input | 32 | Instruction word |
| in_src | input | VL_BITS | Source vector operand |
| in_feat_en | input | 1 | Feature enable; low makes a matching word undefined |
| out_valid | output | 1 | Result qualifier |
| out_match | output | 1 | Word carries this block's fixed opcode bits |
| out_undef | output | 1 | Word matched but is undefined |
| out_dst | output | 5 | Destination register number |
| out_result | output | VL_BITS | Broadcast result |

## Verification
The checker checks the following on every cycle: the two-edge valid latency, that a non-matching word leaves the undefined flag and the data outputs quiet, that an undefined word gives a zero result, that the reserved size field and a low enable raise the undefined flag, and that the destination field is passed through. It also checks that each segment's result has equal upper and lower halves, which holds for every element size. That each segment takes the correct element from its own source segment, and that each size code picks the correct index bits, can only be shown by the bench. The bench does this by comparing outputs against a reference model, using operands in which every byte is distinct.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int SEG_BITS = 128;
  localparam int IDX_W    = 4;
  localparam int REG_W    = 5;

  localparam logic [10:0] OPC_HI  = 11'b00000101_001;
  localparam logic [5:0]  OPC_MID = 6'b001001;

  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_S = 2'd2,
    ESZ_D = 2'd3
  } esz_t;

  typedef struct packed {
    logic             match;
    logic             undef;
    esz_t             esz;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] dst;
  } dec_t;

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
  import sbc_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        feat_en,
  output dec_t        dec
);

  logic [3:0] tsz;
  logic [4:0] imm;
  logic       hit;

  always_comb begin
    tsz = insn[19:16];
    imm = {insn[20], tsz};
    hit = (insn[31:21] == OPC_HI) && (insn[15:10] == OPC_MID);

    dec       = '0;
    dec.match = hit;
    dec.undef = hit && ((tsz == 4'b0000) || !feat_en);
    dec.dst   = hit ? insn[4:0] : '0;

    // lowest set bit of the size field picks the element width
    if (tsz[0]) begin
      dec.esz = ESZ_B;
      dec.idx = imm[4:1];
    end else if (tsz[1]) begin
      dec.esz = ESZ_H;
      dec.idx = {1'b0, imm[4:2]};
    end else if (tsz[2]) begin
      dec.esz = ESZ_S;
      dec.idx = {2'b0, imm[4:3]};
    end else begin
      dec.esz = ESZ_D;
      dec.idx = {3'b0, imm[4]};
    end
  end

endmodule

// File: rtl/sbc_segment.sv
module sbc_segment
  import sbc_pkg::*;
(
  input  logic [SEG_BITS-1:0] seg_in,
  input  esz_t                esz,
  input  logic [IDX_W-1:0]    idx,
  output logic [SEG_BITS-1:0] seg_out
);

  logic [7:0]  el8;
  logic [15:0] el16;
  logic [31:0] el32;
  logic [63:0] el64;

  logic [SEG_BITS-1:0] rep8, rep16, rep32, rep64;

  always_comb begin
    el8  = seg_in[{idx, 3'b000} +: 8];
    el16 = seg_in[{idx[2:0], 4'b0000} +: 16];
    el32 = seg_in[{idx[1:0], 5'b00000} +: 32];
    el64 = seg_in[{idx[0], 6'b000000} +: 64];
  end

  for (genvar k = 0; k < SEG_BITS / 8; k++) begin : g_rep8
    assign rep8[k*8 +: 8] = el8;
  end
  for (genvar k = 0; k < SEG_BITS / 16; k++) begin : g_rep16
    assign rep16[k*16 +: 16] = el16;
  end
  for (genvar k = 0; k < SEG_BITS / 32; k++) begin : g_rep32
    assign rep32[k*32 +: 32] = el32;
  end
  for (genvar k = 0; k < SEG_BITS / 64; k++) begin : g_rep64
    assign rep64[k*64 +: 64] = el64;
  end

  always_comb begin
    unique case (esz)
      ESZ_B:   seg_out = rep8;
      ESZ_H:   seg_out = rep16;
      ESZ_S:   seg_out = rep32;
      default: seg_out = rep64;
    endcase
  end

endmodule

// File: rtl/seg_bcast_unit.sv
module seg_bcast_unit
  import sbc_pkg::*;
#(
  parameter int VL_BITS = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [31:0]        in_insn,
  input  logic [VL_BITS-1:0] in_src,
  input  logic               in_feat_en,
  output logic               out_valid,
  output logic               out_match,
  output logic               out_undef,
  output logic [REG_W-1:0]   out_dst,
  output logic [VL_BITS-1:0] out_result
);

  localparam int NSEG = VL_BITS / SEG_BITS;

  if ((VL_BITS % SEG_BITS) != 0 || VL_BITS < SEG_BITS || VL_BITS > 2048) begin : g_bad_vl
    $error("seg_bcast_unit: VL_BITS must be a multiple of 128 in 128..2048");
  end

  // capture stage
  logic               cap_valid;
  logic [31:0]        cap_insn;
  logic [VL_BITS-1:0] cap_src;
  logic               cap_feat;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_insn  <= '0;
      cap_src   <= '0;
      cap_feat  <= 1'b0;
    end else begin
      cap_valid <= in_valid;
      if (in_valid) begin
        cap_insn <= in_insn;
        cap_src  <= in_src;
        cap_feat <= in_feat_en;
      end
    end
  end

  dec_t dec;

  sbc_decode u_dec (
    .insn    (cap_insn),
    .feat_en (cap_feat),
    .dec     (dec)
  );

  logic [VL_BITS-1:0] bcast;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    sbc_segment u_seg (
      .seg_in  (cap_src[s*SEG_BITS +: SEG_BITS]),
      .esz     (dec.esz),
      .idx     (dec.idx),
      .seg_out (bcast[s*SEG_BITS +: SEG_BITS])
    );
  end

  logic kill;
  assign kill = !dec.match || dec.undef;

  // output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_match  <= 1'b0;
      out_undef  <= 1'b0;
      out_dst    <= '0;
      out_result <= '0;
    end else begin
      out_valid <= cap_valid;
      if (cap_valid) begin
        out_match  <= dec.match;
        out_undef  <= dec.undef;
        out_dst    <= dec.dst;
        out_result <= kill ? '0 : bcast;
      end
    end
  end

endmodule

// File: rtl/sbc_chk.sv
module sbc_chk
  import sbc_pkg::*;
#(
  parameter int VL_BITS = 512
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [31:0]        in_insn,
  input logic               in_feat_en,
  input logic               out_valid,
  input logic               out_match,
  input logic               out_undef,
  input logic [REG_W-1:0]   out_dst,
  input logic [VL_BITS-1:0] out_result
);

  localparam int NSEG = VL_BITS / SEG_BITS;

  logic             v1, v2;
  logic             tz1, tz2;
  logic             fe1, fe2;
  logic [REG_W-1:0] d1, d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0;
      tz1 <= 1'b0; tz2 <= 1'b0;
      fe1 <= 1'b0; fe2 <= 1'b0;
      d1 <= '0; d2 <= '0;
    end else begin
      v1  <= in_valid;
      v2  <= v1;
      tz1 <= (in_insn[19:16] == 4'b0000);
      tz2 <= tz1;
      fe1 <= in_feat_en;
      fe2 <= fe1;
      d1  <= in_insn[4:0];
      d2  <= d1;
    end
  end

  // R10
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  // R1
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_match) |-> (!out_undef && out_dst == '0 && out_result == '0));

  // R2
  rsv_size_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_match && tz2) |-> out_undef);

  // R3
  feat_off_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_match && !fe2) |-> out_undef);

  // R4
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_result == '0));

  // R11
  dst_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_match) |-> (out_dst == d2));

  for (genvar s = 0; s < NSEG; s++) begin : g_half
    // R9
    seg_repl_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_result[s*SEG_BITS +: 64] == out_result[s*SEG_BITS + 64 +: 64]));
  end

endmodule

bind seg_bcast_unit sbc_chk #(.VL_BITS(VL_BITS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_insn    (in_insn),
  .in_feat_en (in_feat_en),
  .out_valid  (out_valid),
  .out_match  (out_match),
  .out_undef  (out_undef),
  .out_dst    (out_dst),
  .out_result (out_result)
);

// File: tb/seg_bcast_unit_tb_top.sv
module seg_bcast_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VL         = 512;
  localparam int NSEG       = VL / 128;
  localparam int WD_CYCLES  = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   in_insn = '0;
  logic [VL-1:0] in_src = '0;
  logic          in_feat_en = 1'b0;
  logic          out_valid, out_match, out_undef;
  logic [4:0]    out_dst;
  logic [VL-1:0] out_result;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_bcast_unit #(.VL_BITS(VL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_src(in_src), .in_feat_en(in_feat_en), .out_valid(out_valid),
    .out_match(out_match), .out_undef(out_undef), .out_dst(out_dst),
    .out_result(out_result)
  );

  typedef struct packed {
    logic          match;
    logic          undef;
    logic [4:0]    dst;
    logic [VL-1:0] res;
    logic [31:0]   issued;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad = 0;
  logic [31:0] cyc = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [VL-1:0] act, input logic [VL-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input logic i1, input logic [3:0] tsz,
                                     input logic [4:0] zn, input logic [4:0] zd);
    return {8'h05, 3'b001, i1, tsz, 6'b001001, zn, zd};
  endfunction

  function automatic logic [VL-1:0] pat(input logic [7:0] seed);
    logic [VL-1:0] v;
    for (int k = 0; k < VL/8; k++) v[k*8 +: 8] = 8'(k * 37) + seed;
    return v;
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [VL-1:0] src,
                                 input logic fe);
    exp_t e;
    int esz, lsb, idx;
    logic [4:0] imm;
    e = '0;
    e.match = (w[31:24] == 8'h05) && (w[23:21] == 3'b001) && (w[15:10] == 6'b001001);
    if (!e.match) return e;
    e.dst = w[4:0];
    if (w[19:16] == 4'b0000 || !fe) begin
      e.undef = 1'b1;
      return e;
    end
    lsb = w[16] ? 0 : w[17] ? 1 : w[18] ? 2 : 3;
    esz = 8 << lsb;
    imm = {w[20], w[19:16]};
    idx = int'(imm >> (lsb + 1));
    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < 128; k++)
        e.res[s*128 + k] = src[s*128 + idx*esz + (k % esz)];
    return e;
  endfunction

  task automatic send(input logic [31:0] w, input logic [VL-1:0] src,
                      input logic fe, input string tag);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_insn = w; in_src = src; in_feat_en = fe;
    e = model(w, src, fe);
    e.issued = cyc;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0; in_insn = 32'hFFFF_FFFF; in_src = '1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected result", VL'(1), VL'(0));
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_match == e.match, t, "match", VL'(out_match), VL'(e.match));
        check(out_undef == e.undef, t, "undef", VL'(out_undef), VL'(e.undef));
        check(out_dst == e.dst, "R11", "dst", VL'(out_dst), VL'(e.dst));
        check(out_result == e.res, t, "result", out_result, e.res);
        check(cyc - e.issued == 2, "R10", "latency", VL'(cyc - e.issued), VL'(2));
      end
    end
  end

  task automatic run_all();
    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_result == '0 && out_dst == '0, "R12",
          "in reset", {out_valid, out_result[VL-2:0]}, '0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_result == '0 && out_undef == 1'b0, "R12",
          "after reset", VL'(out_valid), '0);

    // R5 bytes: index {i1,tsz[3:1]}
    send(mk(1'b0, 4'b0001, 5'd1, 5'd3),  pat(8'h11), 1'b1, "R5");
    send(mk(1'b1, 4'b1111, 5'd2, 5'd30), pat(8'h22), 1'b1, "R5");
    send(mk(1'b1, 4'b0011, 5'd0, 5'd7),  pat(8'h5A), 1'b1, "R9");
    // R6 halfwords
    send(mk(1'b0, 4'b0010, 5'd4, 5'd8),  pat(8'h33), 1'b1, "R6");
    send(mk(1'b1, 4'b1110, 5'd4, 5'd9),  pat(8'h44), 1'b1, "R6");
    send(mk(1'b0, 4'b1010, 5'd4, 5'd10), pat(8'h45), 1'b1, "R9");
    // R7 words
    send(mk(1'b0, 4'b0100, 5'd5, 5'd11), pat(8'h55), 1'b1, "R7");
    send(mk(1'b1, 4'b1100, 5'd5, 5'd12), pat(8'h66), 1'b1, "R7");
    send(mk(1'b1, 4'b0100, 5'd5, 5'd13), pat(8'h67), 1'b1, "R9");
    // R8 doublewords
    send(mk(1'b0, 4'b1000, 5'd6, 5'd14), pat(8'h77), 1'b1, "R8");
    send(mk(1'b1, 4'b1000, 5'd6, 5'd31), pat(8'h88), 1'b1, "R8");
    idle(2);
    // R2 reserved size field
    send(mk(1'b0, 4'b0000, 5'd7, 5'd15), pat(8'h99), 1'b1, "R2");
    send(mk(1'b1, 4'b0000, 5'd7, 5'd16), pat(8'h9A), 1'b1, "R2");
    // R3 / R4 feature disabled, nonzero operand must give zero result
    send(mk(1'b1, 4'b0001, 5'd8, 5'd17), pat(8'hAA), 1'b0, "R3");
    send(mk(1'b0, 4'b1000, 5'd8, 5'd18), '1,         1'b0, "R4");
    // R1 opcode mismatches
    send(mk(1'b0, 4'b0001, 5'd9, 5'd19) ^ 32'h8000_0000, pat(8'hBB), 1'b1, "R1");
    send(mk(1'b0, 4'b0010, 5'd9, 5'd20) ^ 32'h0000_1000, pat(8'hBC), 1'b1, "R1");
    send(mk(1'b0, 4'b0000, 5'd9, 5'd21) ^ 32'h0040_0000, pat(8'hBD), 1'b0, "R1");
    idle(3);
    // R10 data-independent latency: extreme operands, with gaps
    send(mk(1'b1, 4'b0101, 5'd1, 5'd22), '0, 1'b1, "R10");
    idle(1);
    send(mk(1'b1, 4'b0101, 5'd1, 5'd23), '1, 1'b1, "R10");
    send(mk(1'b0, 4'b0110, 5'd1, 5'd24), pat(8'hC3), 1'b1, "R10");
    idle(6);
    check(exp_q.size() == 0, "R10", "drain", VL'(exp_q.size()), '0);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    fork
      run_all();
      begin
        repeat (WD_CYCLES) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) check(1'b0, "R10", "watchdog", VL'(1), VL'(0));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule